// File: doc/BRIEF.md
# Serial Command Frame Streamer

This block drives a batch of memory-write commands to a remote display processor over a two-wire serial link: a clock line and a data line. The host offers one command at a time on a parallel port with a valid/ready handshake. Each command is a 16-bit target address and a 16-bit write value. The block sends them as one 32-bit frame, most significant bit first. The data line changes while the clock is low, and the receiver samples it on each rising clock edge.

The far end commits every frame only when the next frame starts arriving. A batch therefore needs one more frame after its last real command. When the host raises the end-of-batch request, the block sends a frame of all ones. That frame targets the address 0xFFFF, which the receiver ignores. The block then drives a separate receiver-reset line high for a fixed number of system clocks, which returns the receiver's bit counter to the start of a frame. The host cannot start the next batch before that pulse has ended.

Top module: `cmd_spi_streamer`

## Requirements
- R1: Each accepted command leaves as one 32-bit frame on `sdo_o`, sent most significant bit first. The address occupies frame bits 31..16 and the write value occupies bits 15..0.
- R2: `sclk_o` idles low. `sdo_o` holds its value for the whole high phase of `sclk_o`, so every rising edge finds stable data.
- R3: Each high phase of `sclk_o` lasts exactly HALF_CYC system clocks. Within a frame, consecutive rising edges of `sclk_o` are exactly 2*HALF_CYC system clocks apart.
- R4: After reset and between frames, `sclk_o` is low, `sdo_o` is high, `rx_rst_o` is low and `cmd_ready_o` is high.
- R5: A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low from the cycle after acceptance until the frame, and any following reset pulse, has finished.
- R6: An end-of-batch request (`flush_i` high with `cmd_ready_o` high and `cmd_valid_i` low) sends a padding frame of 32 ones.
- R7: After every padding frame, and only then, `rx_rst_o` is high for exactly RST_CYC system clocks. `cmd_ready_o` stays low during the pulse, and `sclk_o` stays low.
- R8: An end-of-batch request that follows no commands still produces the padding frame and the reset pulse.
- R9: When `cmd_valid_i` and `flush_i` are high in the same ready cycle, the command is sent first. The end-of-batch request is not consumed, so a held `flush_i` then produces the padding frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_ready_o | output | 1 | Block is idle and takes a command or an end-of-batch request |
| cmd_addr_i | input | ADDR_W | Target address of the offered command |
| cmd_data_i | input | DATA_W | Write value of the offered command |
| flush_i | input | 1 | End-of-batch request |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data, idles high |
| rx_rst_o | output | 1 | Receiver realignment pulse |

## Verification
The bench builds the block with HALF_CYC set to 4, which is the shortest half period the receiver's synchronizer accepts, and with RST_CYC set to 3. These values keep each frame to 256 system clocks, so several batches fit in a short run. A batch of three commands, an empty batch, a simultaneous command and flush, and commands whose frames look like the padding frame all fit in one run. With the minimum half period, an error of a single cycle in the phase timing or the pulse width shows up as a direct count mismatch.

// File: rtl/cmdstream_pkg.sv
package cmdstream_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_RXRST = 2'd3
  } link_state_e;

endpackage

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int unsigned HALF_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic half_end_o
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign half_end_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

  always_comb begin
    if (!run_i || half_end_o) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_frame_i,
  input  logic               shift_i,
  output logic               msb_o,
  output logic               last_bit_o
);
  localparam int unsigned BW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic               en;

  assign en         = load_i || shift_i;
  assign msb_o      = sreg_q[FRAME_W-1];
  assign last_bit_o = (bit_q == BW'(FRAME_W - 1));

  always_comb begin
    if (load_i) begin
      sreg_d = load_frame_i;
      bit_d  = '0;
    end else begin
      sreg_d = {sreg_q[FRAME_W-2:0], 1'b1};
      bit_d  = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '1;
      bit_q  <= '0;
    end else if (en) begin
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
    end
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int unsigned RST_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = active_i && (cnt_q == CW'(RST_CYC - 1));

  always_comb begin
    if (!active_i || done_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/batch_ctrl.sv
module batch_ctrl
  import cmdstream_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic flush_i,
  input  logic half_end_i,
  input  logic last_bit_i,
  input  logic pulse_done_i,
  output logic ready_o,
  output logic load_o,
  output logic load_pad_o,
  output logic shift_o,
  output logic run_o,
  output logic pulse_active_o,
  output logic sclk_o,
  output logic in_frame_o,
  output logic rx_rst_o
);
  link_state_e state_q, state_d;
  logic pad_q, pad_d;
  logic sclk_q, sclk_d;
  logic frame_q, frame_d;
  logic rxrst_q, rxrst_d;

  always_comb begin
    state_d    = state_q;
    pad_d      = pad_q;
    load_o     = 1'b0;
    load_pad_o = 1'b0;
    shift_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          load_o  = 1'b1;
          pad_d   = 1'b0;
          state_d = ST_LOW;
        end else if (flush_i) begin
          load_o     = 1'b1;
          load_pad_o = 1'b1;
          pad_d      = 1'b1;
          state_d    = ST_LOW;
        end
      end
      ST_LOW: begin
        if (half_end_i) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (half_end_i) begin
          if (last_bit_i) begin
            state_d = pad_q ? ST_RXRST : ST_IDLE;
          end else begin
            shift_o = 1'b1;
            state_d = ST_LOW;
          end
        end
      end
      ST_RXRST: begin
        if (pulse_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    sclk_d  = (state_d == ST_HIGH);
    frame_d = (state_d == ST_LOW) || (state_d == ST_HIGH);
    rxrst_d = (state_d == ST_RXRST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pad_q   <= 1'b0;
      sclk_q  <= 1'b0;
      frame_q <= 1'b0;
      rxrst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pad_q   <= pad_d;
      sclk_q  <= sclk_d;
      frame_q <= frame_d;
      rxrst_q <= rxrst_d;
    end
  end

  assign ready_o        = (state_q == ST_IDLE);
  assign run_o          = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign pulse_active_o = (state_q == ST_RXRST);
  assign sclk_o         = sclk_q;
  assign in_frame_o     = frame_q;
  assign rx_rst_o       = rxrst_q;
endmodule

// File: rtl/cmd_spi_streamer.sv
module cmd_spi_streamer #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HALF_CYC = 5,
  parameter int unsigned RST_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              flush_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              rx_rst_o
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic half_end, last_bit, pulse_done;
  logic load, load_pad, shift, run, pulse_active, in_frame, msb;
  logic [FRAME_W-1:0] load_frame;

  assign load_frame = load_pad ? {FRAME_W{1'b1}} : {cmd_addr_i, cmd_data_i};

  batch_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_int_n),
    .cmd_valid_i    (cmd_valid_i),
    .flush_i        (flush_i),
    .half_end_i     (half_end),
    .last_bit_i     (last_bit),
    .pulse_done_i   (pulse_done),
    .ready_o        (cmd_ready_o),
    .load_o         (load),
    .load_pad_o     (load_pad),
    .shift_o        (shift),
    .run_o          (run),
    .pulse_active_o (pulse_active),
    .sclk_o         (sclk_o),
    .in_frame_o     (in_frame),
    .rx_rst_o       (rx_rst_o)
  );

  sclk_half_timer #(.HALF_CYC(HALF_CYC)) u_half (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .run_i      (run),
    .half_end_o (half_end)
  );

  frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .load_i       (load),
    .load_frame_i (load_frame),
    .shift_i      (shift),
    .msb_o        (msb),
    .last_bit_o   (last_bit)
  );

  pulse_timer #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .active_i (pulse_active),
    .done_o   (pulse_done)
  );

  assign sdo_o = in_frame ? msb : 1'b1;
endmodule

// File: rtl/cmd_spi_streamer_chk.sv
module cmd_spi_streamer_chk #(
  parameter int unsigned HALF_CYC = 5,
  parameter int unsigned RST_CYC  = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_ready_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic rx_rst_o
);
  logic [15:0] hi_cnt_q, rst_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q  <= '0;
      rst_cnt_q <= '0;
    end else begin
      hi_cnt_q  <= sclk_o   ? hi_cnt_q + 16'd1  : 16'd0;
      rst_cnt_q <= rx_rst_o ? rst_cnt_q + 16'd1 : 16'd0;
    end
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!sclk_o && sdo_o && !rx_rst_o)); // R4

  AST_SDO_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o)); // R2

  AST_SDO_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdo_o)); // R2

  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_cnt_q == 16'(HALF_CYC))); // R3

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_rst_o) |-> (rst_cnt_q == 16'(RST_CYC))); // R7

  AST_PULSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o |-> (!cmd_ready_o && !sclk_o)); // R7
endmodule

bind cmd_spi_streamer cmd_spi_streamer_chk #(
  .HALF_CYC (HALF_CYC),
  .RST_CYC  (RST_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ready_o (cmd_ready_o),
  .sclk_o      (sclk_o),
  .sdo_o       (sdo_o),
  .rx_rst_o    (rx_rst_o)
);

// File: tb/tb_cmd_spi_streamer.sv
module tb_cmd_spi_streamer;
  localparam int unsigned HALF = 4;
  localparam int unsigned RSTC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic flush = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic ready, sclk, sdo, rx_rst;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  int exp_pulses = 0;
  int seen_pulses = 0;

  always #5 clk = ~clk;

  cmd_spi_streamer #(.HALF_CYC(HALF), .RST_CYC(RSTC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(ready),
    .cmd_addr_i(addr), .cmd_data_i(data), .flush_i(flush),
    .sclk_o(sclk), .sdo_o(sdo), .rx_rst_o(rx_rst));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
    chk(!sclk && sdo && !rx_rst, "R4 idle levels", {29'd0, sclk, sdo, rx_rst}, 32'h2);
  endtask

  task automatic send_cmd(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; addr = a; data = d;
    wait_ready();
    exp_q.push_back({a, d});
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!ready, "R5 ready low after accept", {31'd0, ready}, 32'd0);
  endtask

  task automatic send_flush();
    @(negedge clk);
    flush = 1'b1;
    wait_ready();
    exp_q.push_back(32'hFFFF_FFFF);
    exp_pulses++;
    @(negedge clk);
    flush = 1'b0;
    chk(!ready, "R5 ready low after flush", {31'd0, ready}, 32'd0);
  endtask

  // monitor: receiver model sampling at sclk rise, compared against the queue
  logic prev_sclk = 1'b0, prev_rst = 1'b0, rise_sdo = 1'b1, sdo_moved = 1'b0;
  logic pad_seen = 1'b0, rdy_bad = 1'b0;
  logic [31:0] shreg = '0;
  int bits = 0, gap = 0, hi_cnt = 0, rst_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      gap++;
      if (sclk && !prev_sclk) begin
        if (bits > 0) chk(gap == 2*HALF, "R3 sclk period", gap, 2*HALF);
        gap = 0;
        rise_sdo = sdo;
        sdo_moved = 1'b0;
        shreg = {shreg[30:0], sdo};
        bits++;
        if (bits == 32) begin
          bits = 0;
          if (exp_q.size() == 0) chk(1'b0, "R1 unexpected frame", shreg, 32'h0);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(shreg == e, (e == 32'hFFFF_FFFF) ? "R6 padding frame" : "R1 command frame", shreg, e);
            if (e == 32'hFFFF_FFFF) pad_seen = 1'b1;
          end
        end
      end
      if (sclk) begin
        hi_cnt++;
        if (sdo != rise_sdo) sdo_moved = 1'b1;
      end
      if (!sclk && prev_sclk) begin
        chk(hi_cnt == HALF, "R3 sclk high width", hi_cnt, HALF);
        chk(!sdo_moved, "R2 sdo stable while sclk high", {31'd0, sdo_moved}, 32'd0);
        hi_cnt = 0;
      end
      if (rx_rst && !prev_rst) begin
        chk(pad_seen, "R7 pulse follows padding frame", {31'd0, pad_seen}, 32'd1);
        pad_seen = 1'b0;
        rst_cnt = 0;
        rdy_bad = 1'b0;
      end
      if (rx_rst) begin
        rst_cnt++;
        if (ready || sclk) rdy_bad = 1'b1;
      end
      if (!rx_rst && prev_rst) begin
        chk(rst_cnt == RSTC, "R7 pulse width", rst_cnt, RSTC);
        chk(!rdy_bad, "R7 ready and sclk low in pulse", {31'd0, rdy_bad}, 32'd0);
        seen_pulses++;
      end
      prev_sclk = sclk;
      prev_rst = rx_rst;
    end
  end

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || !ready || rx_rst) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready && !sclk && sdo && !rx_rst, "R4 reset state", {28'd0, ready, sclk, sdo, rx_rst}, 32'hA);

    // batch of three commands then end of batch
    send_cmd(16'h1234, 16'hABCD);
    send_cmd(16'h0000, 16'h0000);
    send_cmd(16'h8001, 16'h7FFE);
    send_flush();
    drain();
    chk(seen_pulses == 1, "R7 one pulse per batch", seen_pulses, 1);

    // empty batch
    send_flush();
    drain();
    chk(seen_pulses == 2, "R8 empty batch pulse", seen_pulses, 2);

    // command and flush offered together
    @(negedge clk);
    cmd_valid = 1'b1; flush = 1'b1; addr = 16'hC3C3; data = 16'h0F0F;
    wait_ready();
    exp_q.push_back(32'hC3C3_0F0F);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!ready, "R9 ready low after command", {31'd0, ready}, 32'd0);
    wait_ready();
    exp_q.push_back(32'hFFFF_FFFF);
    exp_pulses++;
    @(negedge clk);
    flush = 1'b0;
    drain();
    chk(seen_pulses == 3, "R9 flush kept and served", seen_pulses, 3);

    // command frames resembling padding must not pulse
    send_cmd(16'hFFFF, 16'hFFFF);
    send_cmd(16'hA5A5, 16'h5A5A);
    drain();
    chk(seen_pulses == 3 && !rx_rst, "R7 no pulse without padding", seen_pulses, 3);
    send_flush();
    drain();

    chk(exp_q.size() == 0, "R1 all frames seen", exp_q.size(), 0);
    chk(seen_pulses == exp_pulses, "R8 pulse count", seen_pulses, exp_pulses);
    chk(ready && !sclk && sdo && !rx_rst, "R4 final idle", {28'd0, ready, sclk, sdo, rx_rst}, 32'hA);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule